// File: doc/BRIEF.md
# Reservation Monitor for Locked Load / Conditional Store

This block holds the single per-processor reservation behind an atomic read-modify-write sequence. The load/store pipeline sends it one request per cycle. Each request is either a locked load or a conditional store, in longword (32-bit) or quadword (64-bit) width. The block forms the effective address from a base register value and a signed 16-bit offset. It drives a simple memory port stub in the same cycle and returns a registered response one cycle later.

A locked load that does not fault reads memory and returns the value. It also remembers the naturally aligned 16-byte block it touched and raises the reservation flag. A conditional store writes memory only when the flag is still up and the store lands in the remembered block. It then returns 1, or 0 when the write was refused. Every non-faulting conditional store drops the flag. Other agents report their writes on an invalidate input, and a write that hits the reserved block drops the flag too.

Top module: `llsc_monitor`

## Requirements
- R1: The effective address is `reqBase` plus `reqDisp` sign-extended to 64 bits, modulo 2^64, and it appears on `memAddr` in the request cycle.
- R2: Each request produces `rspValid` exactly one cycle later. A quadword locked load returns `memRdData` unchanged. A longword locked load returns bits 31:0 of `memRdData` sign-extended to 64 bits.
- R3: A non-faulting locked load asserts `memRdEn`, records the 16-byte block (address bits 63:4) and sets the reservation flag.
- R4: A conditional store succeeds only when the flag is set and its address bits 63:4 equal the recorded block. On success it asserts `memWrEn` in the request cycle and returns `rspData` = 1.
- R5: A refused conditional store leaves `memWrEn` low and returns `rspData` = 0.
- R6: Every non-faulting conditional store clears the flag, whether it succeeds or is refused, so a second store without a new locked load is refused.
- R7: An `invValid` whose `invAddr` bits 63:4 match the recorded block clears the flag. An invalidate to any other block leaves the reservation usable.
- R8: A longword access with address bits 1:0 nonzero, or a quadword access with bits 2:0 nonzero, is misaligned. It gives no memory enable, and it answers with `rspFault` = 1 and `rspData` = 0.
- R9: A faulting locked load changes neither the flag nor the recorded block.
- R10: An invalidate in the same cycle as a conditional store to the reserved block makes the store fail. An invalidate in the same cycle as a locked load does not cancel the new reservation the load sets.
- R11: After reset the flag is clear, `rspValid` is low and the memory enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqStoreCond | input | 1 | 1 = conditional store, 0 = locked load |
| reqQuad | input | 1 | 1 = quadword, 0 = longword |
| reqBase | input | 64 | Base register value |
| reqDisp | input | 16 | Signed displacement |
| reqStoreData | input | 64 | Data for a conditional store |
| invValid | input | 1 | Another agent wrote memory this cycle |
| invAddr | input | 64 | Address of that write |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memWrQuad | output | 1 | Write width, 1 = quadword |
| memAddr | output | 64 | Effective address |
| memWrData | output | 64 | Write data |
| memRdData | input | 64 | Read data, returned in the same cycle |
| rspValid | output | 1 | Response valid |
| rspFault | output | 1 | Unaligned-address fault |
| rspData | output | 64 | Loaded value or store result |

## Verification
Two events can fall in the same cycle: an invalidate from another agent, and a pipeline request that reads or consumes the reservation. The bench drives both in one cycle in two ways. First, a conditional store to the reserved block meets an invalidate to a different offset in that block, and the store must return 0 with no write strobe. Second, a locked load to a fresh block meets an invalidate to that same block, and a following conditional store must then succeed. Address sweeps over displacement sign, block edges and low address bits judge the outcome against a reservation model kept in the bench.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [0:0] {
    OP_LOAD_LOCKED = 1'b0,
    OP_STORE_COND  = 1'b1
  } opKind_t;

  typedef struct packed {
    logic respond;
    logic isStore;
    logic fault;
    logic doRead;
    logic doWrite;
    logic takeLock;
    logic dropLock;
  } ctrlStrobe_t;
endpackage

// File: rtl/llsc_datapath.sv
module llsc_datapath
  import llsc_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 64,
  parameter int DISP_W    = 16,
  parameter int BLK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DISP_W-1:0] disp,
  input  logic              quad,
  input  logic [DATA_W-1:0] storeData,
  input  logic [ADDR_W-1:0] invAddr,
  input  logic [DATA_W-1:0] rdData,
  input  ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] effAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              misaligned,
  output logic              sameBlock,
  output logic              invHit,
  output logic              rspValid,
  output logic              rspFault,
  output logic [DATA_W-1:0] rspData
);
  localparam int BLK_LSB  = $clog2(BLK_BYTES);
  localparam int TAG_W    = ADDR_W - BLK_LSB;
  localparam int HALF_W   = DATA_W / 2;
  localparam int QUAD_LSB = $clog2(DATA_W / 8);
  localparam int LONG_LSB = QUAD_LSB - 1;

  logic [TAG_W-1:0]  lockTag;
  logic [DATA_W-1:0] loadValue;
  logic [DATA_W-1:0] rspNext;

  assign effAddr = baseAddr + {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign wrData  = storeData;

  assign misaligned = quad ? (|effAddr[QUAD_LSB-1:0]) : (|effAddr[LONG_LSB-1:0]);
  assign sameBlock  = (effAddr[ADDR_W-1:BLK_LSB] == lockTag);
  assign invHit     = (invAddr[ADDR_W-1:BLK_LSB] == lockTag);

  assign loadValue = quad ? rdData : {{HALF_W{rdData[HALF_W-1]}}, rdData[HALF_W-1:0]};

  always_comb begin
    if (strobe.fault)        rspNext = '0;
    else if (strobe.isStore) rspNext = {{(DATA_W-1){1'b0}}, strobe.doWrite};
    else                     rspNext = loadValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockTag  <= '0;
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strobe.takeLock) lockTag <= effAddr[ADDR_W-1:BLK_LSB];
      rspValid <= strobe.respond;
      if (strobe.respond) begin
        rspFault <= strobe.fault;
        rspData  <= rspNext;
      end
    end
  end
endmodule

// File: rtl/llsc_control.sv
module llsc_control
  import llsc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  opKind_t     reqKind,
  input  logic        misaligned,
  input  logic        sameBlock,
  input  logic        invValid,
  input  logic        invHit,
  output ctrlStrobe_t strobe,
  output logic        lockFlag
);
  logic isLoad, isStore, invKill;

  assign isLoad  = reqValid && (reqKind == OP_LOAD_LOCKED);
  assign isStore = reqValid && (reqKind == OP_STORE_COND);
  assign invKill = invValid && invHit && lockFlag;

  always_comb begin
    strobe          = '0;
    strobe.respond  = reqValid;
    strobe.isStore  = isStore;
    strobe.fault    = reqValid && misaligned;
    strobe.doRead   = isLoad && !misaligned;
    strobe.takeLock = isLoad && !misaligned;
    strobe.doWrite  = isStore && !misaligned && lockFlag && sameBlock && !invKill;
    strobe.dropLock = (isStore && !misaligned) || invKill;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                lockFlag <= 1'b0;
    else if (strobe.takeLock) lockFlag <= 1'b1;
    else if (strobe.dropLock) lockFlag <= 1'b0;
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 64,
  parameter int DISP_W    = 16,
  parameter int BLK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStoreCond,
  input  logic              reqQuad,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [DISP_W-1:0] reqDisp,
  input  logic [DATA_W-1:0] reqStoreData,
  input  logic              invValid,
  input  logic [ADDR_W-1:0] invAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic              memWrQuad,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              rspValid,
  output logic              rspFault,
  output logic [DATA_W-1:0] rspData
);
  ctrlStrobe_t strobe;
  logic misaligned, sameBlock, invHit, lockFlag;

  llsc_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqKind(opKind_t'(reqStoreCond)), .misaligned(misaligned),
    .sameBlock(sameBlock), .invValid(invValid), .invHit(invHit),
    .strobe(strobe), .lockFlag(lockFlag)
  );

  llsc_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DISP_W(DISP_W), .BLK_BYTES(BLK_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .baseAddr(reqBase), .disp(reqDisp),
    .quad(reqQuad), .storeData(reqStoreData), .invAddr(invAddr),
    .rdData(memRdData), .strobe(strobe), .effAddr(memAddr),
    .wrData(memWrData), .misaligned(misaligned), .sameBlock(sameBlock),
    .invHit(invHit), .rspValid(rspValid), .rspFault(rspFault),
    .rspData(rspData)
  );

  assign memRdEn   = strobe.doRead;
  assign memWrEn   = strobe.doWrite;
  assign memWrQuad = reqQuad;
endmodule

// File: rtl/llsc_checker.sv
module llsc_checker #(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 64,
  parameter int BLK_BYTES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqStoreCond,
  input logic              reqQuad,
  input logic              invValid,
  input logic [ADDR_W-1:0] invAddr,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              rspValid,
  input logic              rspFault,
  input logic [DATA_W-1:0] rspData
);
  localparam int BLK_LSB = $clog2(BLK_BYTES);
  logic badAlign;
  logic armed;
  logic [ADDR_W-BLK_LSB-1:0] armTag;

  assign badAlign = reqQuad ? (|memAddr[2:0]) : (|memAddr[1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed  <= 1'b0;
      armTag <= '0;
    end else if (memRdEn) begin
      armed  <= 1'b1;
      armTag <= memAddr[ADDR_W-1:BLK_LSB];
    end else if ((reqValid && reqStoreCond && !badAlign) ||
                 (invValid && invAddr[ADDR_W-1:BLK_LSB] == armTag)) begin
      armed <= 1'b0;
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R2
  AST_READ_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> reqValid && !reqStoreCond); // R3
  AST_WRITE_ONLY_STORE: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> reqValid && reqStoreCond); // R4
  AST_NO_MEM_ON_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWrEn) |-> !badAlign); // R8
  AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> rspData == '0); // R8
  AST_STORE_RESULT_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqStoreCond && !badAlign) |=> rspData == DATA_W'(1) ? $past(memWrEn) : !$past(memWrEn)); // R5
  AST_WRITE_NEEDS_RESERVATION: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> armed && memAddr[ADDR_W-1:BLK_LSB] == armTag); // R6
endmodule

bind llsc_monitor llsc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStoreCond(reqStoreCond),
  .reqQuad(reqQuad), .invValid(invValid), .invAddr(invAddr),
  .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
  .rspValid(rspValid), .rspFault(rspFault), .rspData(rspData)
);

// File: tb/llsc_monitor_tb_top.sv
`timescale 1ns/100ps
module llsc_monitor_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqStoreCond = 1'b0, reqQuad = 1'b0;
  logic [63:0] reqBase = '0, reqStoreData = '0, invAddr = '0;
  logic [15:0] reqDisp = '0;
  logic invValid = 1'b0;
  logic memRdEn, memWrEn, memWrQuad, rspValid, rspFault;
  logic [63:0] memAddr, memWrData, memRdData, rspData;

  int checks = 0, fails = 0;
  bit modelLock = 1'b0;
  logic [59:0] modelTag = '0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [63:0] pat(input logic [63:0] a);
    return {~a[31:0], a[31:0] ^ {a[3], 31'h0000_5A5A}};
  endfunction

  assign memRdData = pat(memAddr);

  llsc_monitor dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStoreCond(reqStoreCond),
    .reqQuad(reqQuad), .reqBase(reqBase), .reqDisp(reqDisp),
    .reqStoreData(reqStoreData), .invValid(invValid), .invAddr(invAddr),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memWrQuad(memWrQuad),
    .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData),
    .rspValid(rspValid), .rspFault(rspFault), .rspData(rspData)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic op(input bit sc, input bit quad, input logic [63:0] base, input logic [15:0] d,
                    input bit inv, input logic [63:0] ia, input string req);
    logic [63:0] ea, expData;
    bit mis, killed, pass;
    ea = base + {{48{d[15]}}, d};
    mis = quad ? (ea[2:0] != 0) : (ea[1:0] != 0);
    killed = inv && modelLock && (ia[63:4] == modelTag);
    pass = sc && !mis && modelLock && (ea[63:4] == modelTag) && !killed;
    if (mis) expData = '0;
    else if (sc) expData = {63'd0, pass};
    else if (quad) expData = pat(ea);
    else expData = {{32{pat(ea)[31]}}, pat(ea)[31:0]};
    @(negedge clk);
    reqValid = 1'b1; reqStoreCond = sc; reqQuad = quad; reqBase = base; reqDisp = d;
    reqStoreData = ~base; invValid = inv; invAddr = ia;
    #1;
    chk(memAddr == ea, {req, " R1 addr"}, memAddr, ea);
    chk(memRdEn == (!sc && !mis), {req, " rd strobe"}, {63'd0, memRdEn}, {63'd0, !sc && !mis});
    chk(memWrEn == pass, {req, " wr strobe"}, {63'd0, memWrEn}, {63'd0, pass});
    @(posedge clk); #1;
    reqValid = 1'b0; invValid = 1'b0;
    chk(rspValid === 1'b1, {req, " R2 rspValid"}, {63'd0, rspValid}, 64'd1);
    chk(rspFault == mis, {req, " R8 fault"}, {63'd0, rspFault}, {63'd0, mis});
    chk(rspData == expData, {req, " data"}, rspData, expData);
    if (!sc && !mis) begin modelLock = 1'b1; modelTag = ea[63:4]; end
    else if ((sc && !mis) || killed) modelLock = 1'b0;
  endtask

  task automatic invOnly(input logic [63:0] ia);
    @(negedge clk);
    invValid = 1'b1; invAddr = ia;
    @(posedge clk); #1;
    invValid = 1'b0;
    chk(rspValid == 1'b0, "R7 idle no rsp", {63'd0, rspValid}, 64'd0);
    if (modelLock && ia[63:4] == modelTag) modelLock = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(rspValid == 1'b0, "R11 rspValid", {63'd0, rspValid}, 64'd0);
    chk(memRdEn == 1'b0 && memWrEn == 1'b0, "R11 enables", {62'd0, memRdEn, memWrEn}, 64'd0);
    op(1, 1, 64'h100, 16'h0, 0, 0, "R11 store after reset fails");

    // R1 R2: address sweep, both widths
    begin
      logic [63:0] bases [3] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h1234_5678_0000_1000};
      logic [15:0] disps [5] = '{16'h0, 16'h0008, 16'h7FF8, 16'h8000, 16'hFFF0};
      foreach (bases[i]) foreach (disps[j]) begin
        op(0, 0, bases[i], disps[j], 0, 0, "R1 R2 long load");
        op(0, 1, bases[i], disps[j] + 16'h0028, 0, 0, "R1 R2 quad load");
      end
    end

    // R3 R4 R5: block boundary sweep around reserved block 0x1000..0x100F
    for (int off = -16; off <= 28; off += 4) begin
      op(0, 0, 64'h1008, 16'h0, 0, 0, "R3 load locked");
      op(1, 0, 64'h1008, 16'(off), 0, 0, "R4 R5 store block test");
    end

    // R6: second store without new reservation fails
    op(0, 1, 64'h2000, 16'h0, 0, 0, "R6 load");
    op(1, 1, 64'h2000, 16'h8, 0, 0, "R6 first store");
    op(1, 1, 64'h2000, 16'h8, 0, 0, "R6 second store refused");
    op(0, 1, 64'h2000, 16'h0, 0, 0, "R6 load");
    op(1, 0, 64'h2010, 16'h0, 0, 0, "R6 refused store elsewhere");
    op(1, 0, 64'h2000, 16'h0, 0, 0, "R6 lock dropped by refused store");

    // R7: invalidate other block ignored, same block kills
    op(0, 0, 64'h3000, 16'h4, 0, 0, "R7 load");
    invOnly(64'h3010);
    op(1, 0, 64'h3000, 16'h0, 0, 0, "R7 other-block inv ignored");
    op(0, 0, 64'h3000, 16'h4, 0, 0, "R7 load");
    invOnly(64'h300C);
    op(1, 0, 64'h3000, 16'h0, 0, 0, "R7 same-block inv kills");

    // R8 R9: misaligned sweep while holding a reservation
    op(0, 1, 64'h4000, 16'h0, 0, 0, "R9 load");
    for (int q = 0; q < 2; q++)
      for (int lo = 0; lo < 8; lo++) begin
        op(0, q[0], 64'h5000 + 64'(lo), 16'h0, 0, 0, "R8 R9 load align sweep");
        op(1, q[0], 64'h4000 + 64'(lo), 16'h0, 0, 0, "R8 store align sweep");
      end
    op(0, 1, 64'h4000, 16'h0, 0, 0, "R9 load");
    op(0, 1, 64'h6004, 16'h0, 0, 0, "R9 faulting load");
    op(1, 1, 64'h4008, 16'h0, 0, 0, "R9 reservation survived fault");

    // R10: same-cycle collisions
    op(0, 0, 64'h7000, 16'h0, 0, 0, "R10 load");
    op(1, 0, 64'h7000, 16'h0, 1, 64'h7008, "R10 store with same-block inv");
    op(1, 0, 64'h7000, 16'h0, 0, 0, "R10 lock gone");
    op(0, 0, 64'h7000, 16'h0, 0, 0, "R10 load old block");
    op(0, 1, 64'h8000, 16'h0, 1, 64'h8000, "R10 load with inv to new block");
    op(1, 1, 64'h8000, 16'h8, 0, 0, "R10 new reservation held");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule